// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache placed between an in-order processor's load/store port and a slower main-memory port. Each 32-bit byte address is split into a tag, a line index and a word select. The cache has 256 lines of 16 words each, which is 16 KB. Every line keeps its data words, an 18-bit tag and a valid flag. A load that finds its line completes in the cycle it is presented. A load that does not find its line stalls the processor while the whole line is brought in from memory. The load then completes against the freshly filled line.

Stores are write-through, and a store that misses does not allocate a line. Every store places one word into a four-entry posted write buffer inside the block, so the processor moves on at once. If the store hits, the cached copy is updated in the same cycle. The processor waits only when the buffer is full. The buffer drains in arrival order and always wins the memory port over a line refill, so a refill never reads memory that is older than a store already accepted.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_ready` high. The access completes at the clock edge where `cpu_req` and `cpu_ready` are both high. On the memory side, a request completes at the edge where `mem_req` and `mem_gnt` are both high. A line read is one request carrying the line's base address. Memory answers it with 16 `mem_rvalid` beats, word 0 first.

Top module: `wtc_dcache`

## Requirements
- R1: Address bits [1:0] are ignored. Bits [5:2] pick the word in the line, bits [13:6] pick the line, and bits [31:14] form the tag. Addresses that differ only in bits [1:0] return the same word.
- R2: After reset every line is invalid, so the first load to any address is a miss.
- R3: A load whose line is valid and whose stored tag equals the address tag completes with `cpu_ready` high in the first cycle and returns the cached word.
- R4: A load miss holds `cpu_ready` low until the refill is done. It issues exactly one memory read whose address is the line base (bits [5:0] zero).
- R5: After the 16 refill beats are written in order, the line becomes valid with the new tag. The stalled load then completes and returns the current memory value of its word.
- R6: Each accepted store produces exactly one memory write. That write carries the word-aligned address and the data, and writes reach memory in the order the stores were accepted. A memory request holds its address and data stable until it is granted.
- R7: A store that misses leaves the line unallocated, so a later load to it misses. That load returns the stored data.
- R8: A store is accepted without stall while the write buffer holds fewer than 4 entries. When the buffer is full, the store stalls until an entry drains.
- R9: A line refill read is issued only when the write buffer is empty.
- R10: Two addresses with the same index and different tags replace each other, so each load after the other misses.
- R11: A store that hits updates the cached word, so a following load hits and returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_ready is high |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 32 | Refill beat data |

## Verification
The bench targets a load that misses on a line while stores to that same line are still queued. A cache that let the refill overtake the write buffer would return stale data there. It also holds memory grants off so that the buffer fills. A design with an off-by-one in its full flag would then either drop a store or stall one early. Conflict pairs that share an index but differ in tag expose a cache that compares too few tag bits: such a cache hits on the wrong line. A store to an absent line followed by a load catches a cache that allocates on a store miss: it would show no refill request and return the wrong hit timing.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_DRAIN,
        FS_REQ,
        FS_FILL
    } fill_state_e;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int DEPTH = 4,
    parameter int AW    = 30,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            rp;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } wb_t;

    wb_t q, d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push) begin
            d.addr[q.wp] = push_addr;
            d.data[q.wp] = push_data;
            d.wp         = bump(q.wp);
        end
        if (pop) begin
            d.rp = bump(q.rp);
        end
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_addr = q.addr[q.rp];
    assign head_data = q.data[q.rp];
    assign empty     = (q.cnt == '0);
    assign full      = (q.cnt == CW'(DEPTH));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wtc_tags.sv
module wtc_tags #(
    parameter int LINES = 256,
    parameter int TW    = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [TW-1:0]            rd_tag,
    output logic                     rd_valid,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TW-1:0]            wr_tag
);
    logic [LINES-1:0] valid_q, valid_d;
    logic [TW-1:0]    tag_mem [LINES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
    parameter int LINES = 256,
    parameter int WORDS = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    input  logic [$clog2(WORDS)-1:0] rd_word,
    output logic [DW-1:0]            rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [$clog2(WORDS)-1:0] wr_word,
    input  logic [DW-1:0]            wr_data
);
    localparam int ENTRIES = LINES * WORDS;

    logic [DW-1:0] arr [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) arr[{wr_idx, wr_word}] <= wr_data;
    end

    assign rd_data = arr[{rd_idx, rd_word}];
endmodule

// File: rtl/wtc_dcache.sv
module wtc_dcache
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 16,
    parameter int NUM_LINES  = 256,
    parameter int WB_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W - BYTE_W;
    localparam int WADDR_W = ADDR_W - BYTE_W;

    typedef struct packed {
        fill_state_e       st;
        logic [OFF_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
    } ctl_t;

    ctl_t q, d;

    // address decode
    logic [OFF_W-1:0] a_word;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    assign a_word = cpu_addr[BYTE_W +: OFF_W];
    assign a_idx  = cpu_addr[BYTE_W + OFF_W +: IDX_W];
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    logic [TAG_W-1:0]  st_tag;
    logic              st_valid;
    logic              hit;
    logic              wb_push, wb_pop, wb_empty, wb_full;
    logic [WADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;
    logic              dw_en, tw_en;
    logic [IDX_W-1:0]  dw_idx;
    logic [OFF_W-1:0]  dw_word;
    logic [DATA_W-1:0] dw_data;

    assign hit = st_valid && (st_tag == a_tag);

    always_comb begin
        d         = q;
        cpu_ready = 1'b0;
        wb_push   = 1'b0;
        dw_en     = 1'b0;
        dw_idx    = a_idx;
        dw_word   = a_word;
        dw_data   = cpu_wdata;
        tw_en     = 1'b0;
        unique case (q.st)
            FS_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (!wb_full) begin
                            cpu_ready = 1'b1;
                            wb_push   = 1'b1;
                            dw_en     = hit;
                        end
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        d.st  = FS_DRAIN;
                        d.idx = a_idx;
                        d.tag = a_tag;
                    end
                end
            end
            FS_DRAIN: begin
                if (wb_empty) d.st = FS_REQ;
            end
            FS_REQ: begin
                if (mem_gnt) begin
                    d.st  = FS_FILL;
                    d.cnt = '0;
                end
            end
            FS_FILL: begin
                dw_idx  = q.idx;
                dw_word = q.cnt;
                dw_data = mem_rdata;
                if (mem_rvalid) begin
                    dw_en = 1'b1;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == OFF_W'(LINE_WORDS - 1)) begin
                        tw_en = 1'b1;
                        d.st  = FS_IDLE;
                    end
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: FS_IDLE, cnt: '0, idx: '0, tag: '0};
        else        q <= d;
    end

    // memory port: write buffer first, refill only from REQ state
    assign mem_req   = (q.st == FS_REQ) || ((q.st != FS_FILL) && !wb_empty);
    assign mem_we    = (q.st != FS_REQ);
    assign mem_addr  = (q.st == FS_REQ) ? {q.tag, q.idx, {(OFF_W + BYTE_W){1'b0}}}
                                        : {wb_head_addr, {BYTE_W{1'b0}}};
    assign mem_wdata = wb_head_data;
    assign wb_pop    = mem_req && mem_we && mem_gnt;

    wtc_wbuf #(.DEPTH(WB_DEPTH), .AW(WADDR_W), .DW(DATA_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_addr (cpu_addr[ADDR_W-1:BYTE_W]),
        .push_data (cpu_wdata),
        .pop       (wb_pop),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .empty     (wb_empty),
        .full      (wb_full)
    );

    wtc_tags #(.LINES(NUM_LINES), .TW(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (a_idx),
        .rd_tag   (st_tag),
        .rd_valid (st_valid),
        .wr_en    (tw_en),
        .wr_idx   (q.idx),
        .wr_tag   (q.tag)
    );

    wtc_data #(.LINES(NUM_LINES), .WORDS(LINE_WORDS), .DW(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_word (a_word),
        .rd_data (cpu_rdata),
        .wr_en   (dw_en),
        .wr_idx  (dw_idx),
        .wr_word (dw_word),
        .wr_data (dw_data)
    );

    a_r4_stall_during_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != FS_IDLE) |-> !cpu_ready);
    a_r9_refill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> wb_empty);
    a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));
    a_r5_fill_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FS_FILL && mem_rvalid && q.cnt == OFF_W'(LINE_WORDS - 1)) |=> (q.st == FS_IDLE));
endmodule

// File: tb/tb_wtc_dcache.sv
module tb_wtc_dcache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wtc_dcache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [31:0] mem_w [int unsigned];   // what memory actually holds
    logic [31:0] ref_w [int unsigned];   // processor view
    logic [63:0] exp_wq [$];             // {word addr, data} in acceptance order
    bit          ev [256];
    logic [17:0] et [256];
    logic [31:0] exp_line = '0;
    bit          gnt_block = 0;

    function automatic logic [31:0] init_word(input int unsigned wa);
        return (wa * 32'h9E37_79B1) ^ 32'hC0DE_0000;
    endfunction
    function automatic logic [31:0] mem_rd(input int unsigned wa);
        return mem_w.exists(wa) ? mem_w[wa] : init_word(wa);
    endfunction
    function automatic logic [31:0] ref_rd(input int unsigned wa);
        return ref_w.exists(wa) ? ref_w[wa] : init_word(wa);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        int beats_left = 0;
        int beat = 0;
        logic [31:0] base = '0;
        forever begin
            @(negedge clk);
            #2;
            mem_rvalid = 1'b0;
            if (beats_left > 0 && ($urandom % 3) != 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_rd((base >> 2) + beat);
                beat++;
                beats_left--;
            end
            mem_gnt = 1'b0;
            if (mem_req && !gnt_block && ($urandom % 4) != 0) begin
                mem_gnt = 1'b1;
                if (mem_we) begin
                    if (exp_wq.size() == 0) begin
                        chk(0, "R6 unexpected write", {mem_addr, mem_wdata}, '0);
                    end else begin
                        logic [63:0] e;
                        e = exp_wq.pop_front();
                        chk({2'b00, mem_addr[31:2], mem_wdata} == e && mem_addr[1:0] == 2'b00,
                            "R6 write order/content", {2'b00, mem_addr[31:2], mem_wdata}, e);
                    end
                    mem_w[mem_addr >> 2] = mem_wdata;
                end else begin
                    chk(exp_wq.size() == 0, "R9 refill with stores pending", exp_wq.size(), 0);
                    chk(mem_addr == exp_line, "R4 refill line address", mem_addr, exp_line);
                    base = mem_addr;
                    beat = 0;
                    beats_left = 16;
                end
            end
        end
    end

    task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       input string tag, output int stalls, output bit was_hit_exp);
        int unsigned wa;
        logic [7:0]  idx;
        logic [17:0] tg;
        logic [31:0] got;
        wa  = a >> 2;
        idx = a[13:6];
        tg  = a[31:14];
        was_hit_exp = ev[idx] && et[idx] == tg;
        exp_line = {a[31:6], 6'b0};
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stalls = 0;
        forever begin
            #1;
            if (cpu_ready || stalls > 3000) break;
            stalls++;
            @(negedge clk);
        end
        got = cpu_rdata;
        if (we) begin
            ref_w[wa] = wd;
            exp_wq.push_back({2'b00, a[31:2], wd});
        end else begin
            chk(got == ref_rd(wa), {tag, " load data"}, got, ref_rd(wa));
            if (was_hit_exp) chk(stalls == 0, {tag, " R3 hit timing"}, stalls, 0);
            else             chk(stalls > 0,  {tag, " R4 miss stall"}, stalls, 1);
            ev[idx] = 1; et[idx] = tg;
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_wq.size() != 0 && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        int s;
        bit h;
        logic [31:0] a;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "reset mem_req idle", mem_req, 0);
        chk(cpu_ready == 1'b0, "reset ready idle", cpu_ready, 0);

        // R2: first load after reset misses
        acc(0, 32'h0001_2340, 0, "R2", s, h);
        chk(!h && s > 16, "R2 cold miss", s, 17);

        // R1: byte offset ignored, same line other word hits
        acc(0, 32'h0001_2343, 0, "R1 byte3", s, h);
        chk(s == 0, "R1 byte bits ignored", s, 0);
        acc(0, 32'h0001_237C, 0, "R1 word15", s, h);
        chk(s == 0, "R1 same line hit", s, 0);

        // R11: store hit then load
        acc(1, 32'h0001_2344, 32'hDEAD_BEEF, "R11 store", s, h);
        chk(s == 0, "R11 store no stall", s, 0);
        acc(0, 32'h0001_2344, 0, "R11 reload", s, h);
        chk(s == 0, "R11 hit after store", s, 0);

        // R10: conflict pair
        acc(0, 32'h0001_2340 + 32'h4000, 0, "R10 conflict", s, h);
        chk(s > 0, "R10 evict miss", s, 1);
        acc(0, 32'h0001_2340, 0, "R10 back", s, h);
        chk(s > 0, "R10 re-miss", s, 1);

        // R7: store miss no allocate, then load (R9 refill after stores)
        acc(1, 32'h0080_0100, 32'h1234_5678, "R7 store", s, h);
        acc(1, 32'h0080_0104, 32'hCAFE_F00D, "R7 store2", s, h);
        acc(0, 32'h0080_0104, 0, "R7 load", s, h);
        chk(s > 0, "R7 no allocate on store miss", s, 1);

        // R8: full buffer stalls
        drain();
        gnt_block = 1;
        for (int i = 0; i < 4; i++) begin
            acc(1, 32'h0100_0000 + 32'(i * 4), 32'hA000_0000 + 32'(i), "R8 fill", s, h);
            chk(s == 0, "R8 store accepted below full", s, 0);
        end
        fork
            begin repeat (8) @(negedge clk); gnt_block = 0; end
        join_none
        acc(1, 32'h0100_0010, 32'hA000_0004, "R8 fifth", s, h);
        chk(s >= 8, "R8 stall when full", s, 8);
        acc(0, 32'h0100_0010, 0, "R8 readback", s, h);

        // constrained random mix (R3 R4 R5 R6 R10 R11)
        for (int i = 0; i < 300; i++) begin
            a = {12'h000, 4'($urandom % 3), 2'b00, 8'($urandom % 6), 4'($urandom % 16), 2'($urandom % 4)};
            if ($urandom % 2) acc(1, a, $urandom, "R6 rnd store", s, h);
            else              acc(0, a, 0, "R5 rnd load", s, h);
        end

        // R6: memory consistent with processor view
        drain();
        foreach (ref_w[k]) begin
            chk(mem_rd(k) == ref_w[k], "R6 write-through consistency", mem_rd(k), ref_w[k]);
        end
        summary();
    end
endmodule